// File: doc/BRIEF.md
# PCI configuration access translator

This block connects a local register-style bus to the request side of a PCI-style initiator. A local access whose two top address bits are `10` (0x8000_0000 to 0xBFFF_FFFF) becomes a single PCI transaction. A sticky select bit in the control register chooses the kind of transaction. With the bit clear, the access becomes a memory cycle. With the bit set, it becomes a Type 0 configuration cycle. Every other local address reaches the block's own two registers: a control word and an abort status word.

For a configuration cycle the block reads the device, function and register number from the local address. It builds the one-hot configuration address from them, drives the matching IDSEL line, and extracts the addressed byte lanes of a read. A sub-word write is done as a read of the old word followed by a write of the merged word. A target abort ends the access with an error and all-ones data, and it sets a sticky status flag. Software clears that flag by writing a one to it. A two-bit field in the control word drives the bus reset pin low or high, or leaves it as an input.

Only one access is in flight at a time. An FSM carries each access through the states IDLE, DISPATCH, REG, CFG_RD, CFG_WR, MEM_RD, MEM_WR and RESP. The transitions are:
- IDLE to DISPATCH when `lb_valid` is seen.
- DISPATCH to REG when the address is outside the window.
- DISPATCH to RESP when the address is in the window, configuration mode is selected and the device is out of range.
- DISPATCH to CFG_RD when configuration mode is selected and the device is in range.
- DISPATCH to MEM_RD or MEM_WR when memory mode is selected.
- REG to RESP.
- CFG_RD to RESP on an abort, or on an ack for a read.
- CFG_RD to CFG_WR on an ack for a write.
- CFG_WR, MEM_RD and MEM_WR to RESP on an ack or an abort.
- RESP to IDLE.

Top module: `pcx_bridge`

## Requirements
- R1: A local address with `lb_addr[31:30] == 2'b10` produces a PCI transaction. Any other address is a register access with no PCI request: `lb_addr[2]=0` selects the control word and `lb_addr[2]=1` selects the status word.
- R2: In memory mode, the block makes one request with `pci_cfg=0` and `pci_addr = {ctrl[3:2], lb_addr[29:0]}`. A write passes the full `lb_wdata`, and a read returns `pci_rdata` unchanged.
- R3: Control bit 1 selects configuration mode. The configuration fields are device `lb_addr[15:11]`, function `lb_addr[10:8]` and register `lb_addr[7:0]`. The configuration address is `(1 << (13+device)) | (function << 8) | (register & ~3)`, and `pci_idsel` carries its bits 19:13. `pci_idsel` is zero in memory cycles. The control word reads back as bits 5:1 only.
- R4: In configuration mode, a device number above 18, or one with 13+device ≥ 20, is rejected with no PCI request. The access completes with `lb_err=1` and `lb_rdata=32'hFFFF_FFFF`.
- R5: A configuration read shifts the word right by 8 × `lb_addr[1:0]`. It then masks to the size: `lb_size` 0 gives one byte, 1 gives two bytes, and 2 or 3 give four bytes.
- R6: A configuration write first issues a read (`pci_write=0`). It then issues a write whose data is the old word with the addressed lanes replaced by `lb_wdata`.
- R7: An abort sets status bit 26. The access then ends with `lb_err=1` and `lb_rdata=32'hFFFF_FFFF`. An abort during the read phase of a configuration write cancels the write phase.
- R8: Writing a one to status bit 26 clears it. Writing a zero there leaves it unchanged.
- R9: Control bits 5:4 select the reset pin mode. Value 1 drives the pin low. Value 2 drives it high. Values 0 and 3 release it (`pci_rst_oe=0`).
- R10: `pci_req` stays high with a stable address until `pci_ack` or `pci_abort` arrives. `lb_ready` is a one-cycle pulse, given only after the transaction has finished.
- R11: After reset, the control and status words are zero, and there is no request, no ready and no driven reset pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lb_valid | input | 1 | Local request valid, held until ready |
| lb_write | input | 1 | Local request is a write |
| lb_addr | input | 32 | Local address |
| lb_wdata | input | 32 | Local write data (low-aligned for sub-word) |
| lb_size | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| lb_ready | output | 1 | Completion pulse |
| lb_rdata | output | 32 | Read data, valid with ready |
| lb_err | output | 1 | Access failed (rejected or aborted) |
| pci_req | output | 1 | PCI-side request |
| pci_cfg | output | 1 | Request is a configuration cycle |
| pci_write | output | 1 | Request is a write |
| pci_addr | output | 32 | Bus address |
| pci_wdata | output | 32 | Bus write data |
| pci_idsel | output | 7 | One-hot IDSEL lines |
| pci_ack | input | 1 | Target completed the request |
| pci_abort | input | 1 | Target aborted the request |
| pci_rdata | input | 32 | Target read data |
| pci_rst_oe | output | 1 | Reset pin output enable |
| pci_rst_out | output | 1 | Reset pin level when enabled |

## Verification
The bench targets the following corner cases:
- Device numbers just beyond the window (7) and beyond the hard limit (19). A design that checked only the computed address would lose the shifted-out bit and issue a cycle to device 0.
- Sub-word lanes at non-zero offsets, including a word-size read at offset 2. A wrong shift or mask corrupts neighbouring bytes, or reads the wrong lanes.
- An abort in each phase of a read-modify-write. A design that ignored the first abort would still write a stale merged word.
- A write of zero to the status word. A design that cleared on any write would lose the abort flag.
- Reset mode 3. Treated wrongly, it would drive the reset pin.

Responses are delayed by several cycles. This checks that the request holds steady, and that ready is not raised early.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISPATCH,
        ST_REG,
        ST_CFG_RD,
        ST_CFG_WR,
        ST_MEM_RD,
        ST_MEM_WR,
        ST_RESP
    } pcx_state_e;

    typedef enum logic [1:0] {
        PIN_RELEASE = 2'd0,
        PIN_LOW     = 2'd1,
        PIN_HIGH    = 2'd2,
        PIN_SPARE   = 2'd3
    } pcx_pin_mode_e;

    localparam int CTL_SEL_BIT   = 1;
    localparam int CTL_HI_LSB    = 2;
    localparam int CTL_PIN_LSB   = 4;
    localparam int CTL_TOP_BIT   = 5;
    localparam int STS_ABORT_BIT = 26;

endpackage

// File: rtl/pcx_ctrl_regs.sv
module pcx_ctrl_regs
    import pcx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic [4:0] ctrl_bits,
    input  logic       wr_status,
    input  logic       clr_bit,
    input  logic       abort_set,
    output logic       cfg_sel,
    output logic [1:0] hi_bits,
    output logic [1:0] pin_mode,
    output logic       abort_flag,
    output logic       rst_oe,
    output logic       rst_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_sel  <= 1'b0;
            hi_bits  <= 2'b00;
            pin_mode <= 2'b00;
        end else if (wr_ctrl) begin
            cfg_sel  <= ctrl_bits[0];
            hi_bits  <= ctrl_bits[2:1];
            pin_mode <= ctrl_bits[4:3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort_flag <= 1'b0;
        end else if (abort_set) begin
            abort_flag <= 1'b1;
        end else if (wr_status && clr_bit) begin
            abort_flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (pcx_pin_mode_e'(pin_mode))
            PIN_LOW: begin
                rst_oe  = 1'b1;
                rst_out = 1'b0;
            end
            PIN_HIGH: begin
                rst_oe  = 1'b1;
                rst_out = 1'b1;
            end
            default: begin
                rst_oe  = 1'b0;
                rst_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pcx_cfg_addr.sv
module pcx_cfg_addr #(
    parameter int AW         = 32,
    parameter int DEV_W      = 5,
    parameter int FN_W       = 3,
    parameter int REG_W      = 8,
    parameter int IDSEL_BASE = 13,
    parameter int WIN_BITS   = 20,
    parameter int MAX_DEV    = 18
) (
    input  logic [DEV_W-1:0]               dev,
    input  logic [FN_W-1:0]                func,
    input  logic [REG_W-3:0]               reg_dw,
    output logic                           in_range,
    output logic [WIN_BITS-IDSEL_BASE-1:0] idsel,
    output logic [AW-1:0]                  cfg_addr
);

    localparam int IDSEL_N = WIN_BITS - IDSEL_BASE;

    assign in_range = (32'(dev) <= MAX_DEV) && (32'(dev) + IDSEL_BASE < WIN_BITS);

    for (genvar i = 0; i < IDSEL_N; i++) begin : g_idsel
        assign idsel[i] = (32'(dev) == 32'(i));
    end

    always_comb begin
        cfg_addr = '0;
        cfg_addr[WIN_BITS-1:IDSEL_BASE] = idsel;
        cfg_addr[REG_W+FN_W-1:REG_W]    = func;
        cfg_addr[REG_W-1:2]             = reg_dw;
    end

endmodule

// File: rtl/pcx_lane_unit.sv
module pcx_lane_unit #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] old_word,
    input  logic [DW-1:0] new_data,
    input  logic [1:0]    size,
    input  logic [1:0]    ofs,
    output logic [DW-1:0] extracted,
    output logic [DW-1:0] merged
);

    logic [DW-1:0] mask;
    logic [4:0]    shamt;

    always_comb begin
        unique case (size)
            2'd0:    mask = DW'(32'h0000_00FF);
            2'd1:    mask = DW'(32'h0000_FFFF);
            default: mask = '1;
        endcase
        shamt     = {ofs, 3'b000};
        extracted = (old_word >> shamt) & mask;
        merged    = (old_word & ~(mask << shamt)) | ((new_data & mask) << shamt);
    end

endmodule

// File: rtl/pcx_bridge.sv
module pcx_bridge
    import pcx_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int DEV_W      = 5,
    parameter int FN_W       = 3,
    parameter int REG_W      = 8,
    parameter int IDSEL_BASE = 13,
    parameter int WIN_BITS   = 20,
    parameter int MAX_DEV    = 18
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           lb_valid,
    input  logic                           lb_write,
    input  logic [AW-1:0]                  lb_addr,
    input  logic [DW-1:0]                  lb_wdata,
    input  logic [1:0]                     lb_size,
    output logic                           lb_ready,
    output logic [DW-1:0]                  lb_rdata,
    output logic                           lb_err,
    output logic                           pci_req,
    output logic                           pci_cfg,
    output logic                           pci_write,
    output logic [AW-1:0]                  pci_addr,
    output logic [DW-1:0]                  pci_wdata,
    output logic [WIN_BITS-IDSEL_BASE-1:0] pci_idsel,
    input  logic                           pci_ack,
    input  logic                           pci_abort,
    input  logic [DW-1:0]                  pci_rdata,
    output logic                           pci_rst_oe,
    output logic                           pci_rst_out
);

    localparam int IDSEL_N = WIN_BITS - IDSEL_BASE;
    localparam int DEV_LSB = REG_W + FN_W;

    pcx_state_e state_q, state_d;

    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q, merged_q;
    logic [1:0]    size_q;
    logic          write_q, err_q;

    logic          cfg_sel, abort_flag;
    logic [1:0]    hi_bits, pin_mode;
    logic          in_win, in_range, abort_set;
    logic [IDSEL_N-1:0] idsel;
    logic [AW-1:0] cfg_addr;
    logic [DW-1:0] extracted, merged, reg_rd;

    assign in_win    = (addr_q[AW-1:AW-2] == 2'b10);
    assign abort_set = pci_req && pci_abort;

    pcx_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    ((state_q == ST_REG) && write_q && !addr_q[2]),
        .ctrl_bits  (wdata_q[CTL_TOP_BIT:CTL_SEL_BIT]),
        .wr_status  ((state_q == ST_REG) && write_q && addr_q[2]),
        .clr_bit    (wdata_q[STS_ABORT_BIT]),
        .abort_set  (abort_set),
        .cfg_sel    (cfg_sel),
        .hi_bits    (hi_bits),
        .pin_mode   (pin_mode),
        .abort_flag (abort_flag),
        .rst_oe     (pci_rst_oe),
        .rst_out    (pci_rst_out)
    );

    pcx_cfg_addr #(
        .AW         (AW),
        .DEV_W      (DEV_W),
        .FN_W       (FN_W),
        .REG_W      (REG_W),
        .IDSEL_BASE (IDSEL_BASE),
        .WIN_BITS   (WIN_BITS),
        .MAX_DEV    (MAX_DEV)
    ) u_cfg_addr (
        .dev      (addr_q[DEV_LSB+DEV_W-1:DEV_LSB]),
        .func     (addr_q[DEV_LSB-1:REG_W]),
        .reg_dw   (addr_q[REG_W-1:2]),
        .in_range (in_range),
        .idsel    (idsel),
        .cfg_addr (cfg_addr)
    );

    pcx_lane_unit #(.DW(DW)) u_lanes (
        .old_word  (pci_rdata),
        .new_data  (wdata_q),
        .size      (size_q),
        .ofs       (addr_q[1:0]),
        .extracted (extracted),
        .merged    (merged)
    );

    always_comb begin
        reg_rd = '0;
        if (addr_q[2]) begin
            reg_rd[STS_ABORT_BIT] = abort_flag;
        end else begin
            reg_rd[CTL_SEL_BIT]                 = cfg_sel;
            reg_rd[CTL_HI_LSB+1:CTL_HI_LSB]     = hi_bits;
            reg_rd[CTL_PIN_LSB+1:CTL_PIN_LSB]   = pin_mode;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (lb_valid) state_d = ST_DISPATCH;
            ST_DISPATCH: begin
                if (!in_win)        state_d = ST_REG;
                else if (cfg_sel)   state_d = in_range ? ST_CFG_RD : ST_RESP;
                else if (write_q)   state_d = ST_MEM_WR;
                else                state_d = ST_MEM_RD;
            end
            ST_REG:      state_d = ST_RESP;
            ST_CFG_RD: begin
                if (pci_abort)      state_d = ST_RESP;
                else if (pci_ack)   state_d = write_q ? ST_CFG_WR : ST_RESP;
            end
            ST_CFG_WR, ST_MEM_RD, ST_MEM_WR:
                if (pci_abort || pci_ack) state_d = ST_RESP;
            ST_RESP:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        pci_req   = 1'b0;
        pci_cfg   = 1'b0;
        pci_write = 1'b0;
        pci_wdata = '0;
        unique case (state_q)
            ST_CFG_RD: begin
                pci_req = 1'b1;
                pci_cfg = 1'b1;
            end
            ST_CFG_WR: begin
                pci_req   = 1'b1;
                pci_cfg   = 1'b1;
                pci_write = 1'b1;
                pci_wdata = merged_q;
            end
            ST_MEM_RD: pci_req = 1'b1;
            ST_MEM_WR: begin
                pci_req   = 1'b1;
                pci_write = 1'b1;
                pci_wdata = wdata_q;
            end
            default: ;
        endcase
        pci_addr  = pci_cfg ? cfg_addr : {hi_bits, addr_q[AW-3:0]};
        pci_idsel = pci_cfg ? idsel : '0;
        lb_ready  = (state_q == ST_RESP);
        lb_rdata  = rdata_q;
        lb_err    = err_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            size_q   <= 2'b00;
            write_q  <= 1'b0;
            rdata_q  <= '0;
            merged_q <= '0;
            err_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (lb_valid) begin
                    addr_q  <= lb_addr;
                    wdata_q <= lb_wdata;
                    size_q  <= lb_size;
                    write_q <= lb_write;
                    rdata_q <= '0;
                    err_q   <= 1'b0;
                end
                ST_DISPATCH: if (in_win && cfg_sel && !in_range) begin
                    err_q   <= 1'b1;
                    rdata_q <= '1;
                end
                ST_REG: if (!write_q) rdata_q <= reg_rd;
                ST_CFG_RD: begin
                    if (pci_abort) begin
                        err_q   <= 1'b1;
                        rdata_q <= '1;
                    end else if (pci_ack) begin
                        merged_q <= merged;
                        if (!write_q) rdata_q <= extracted;
                    end
                end
                ST_MEM_RD: begin
                    if (pci_abort) begin
                        err_q   <= 1'b1;
                        rdata_q <= '1;
                    end else if (pci_ack) begin
                        rdata_q <= pci_rdata;
                    end
                end
                ST_CFG_WR, ST_MEM_WR: if (pci_abort) begin
                    err_q   <= 1'b1;
                    rdata_q <= '1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pcx_bridge_chk.sv
module pcx_bridge_chk #(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int IDSEL_N = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lb_ready,
    input logic               lb_err,
    input logic [DW-1:0]      lb_rdata,
    input logic               pci_req,
    input logic               pci_cfg,
    input logic               pci_write,
    input logic [AW-1:0]      pci_addr,
    input logic [IDSEL_N-1:0] pci_idsel,
    input logic               pci_ack,
    input logic               pci_abort
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req && !pci_ack && !pci_abort |=> pci_req && $stable(pci_addr) && $stable(pci_write)); // R10

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        lb_ready |=> !lb_ready); // R10

    AST_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        lb_ready |-> !pci_req); // R10

    AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req && pci_abort |=> lb_ready && lb_err); // R7

    AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        lb_ready && lb_err |-> lb_rdata == '1); // R7

    AST_IDSEL_MEM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req && !pci_cfg |-> pci_idsel == '0); // R3

    AST_IDSEL_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req && pci_cfg |-> $countones(pci_idsel) == 1); // R3

    AST_CFG_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_req) && pci_cfg |-> !pci_write); // R6

endmodule

bind pcx_bridge pcx_bridge_chk #(
    .AW      (AW),
    .DW      (DW),
    .IDSEL_N (WIN_BITS - IDSEL_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lb_ready  (lb_ready),
    .lb_err    (lb_err),
    .lb_rdata  (lb_rdata),
    .pci_req   (pci_req),
    .pci_cfg   (pci_cfg),
    .pci_write (pci_write),
    .pci_addr  (pci_addr),
    .pci_idsel (pci_idsel),
    .pci_ack   (pci_ack),
    .pci_abort (pci_abort)
);

// File: tb/pcx_bridge_test.sv
`timescale 1ns/1ps
module pcx_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lb_valid = 1'b0;
    logic        lb_write = 1'b0;
    logic [31:0] lb_addr = '0;
    logic [31:0] lb_wdata = '0;
    logic [1:0]  lb_size = 2'd2;
    logic        lb_ready, lb_err;
    logic [31:0] lb_rdata;
    logic        pci_req, pci_cfg, pci_write;
    logic [31:0] pci_addr, pci_wdata;
    logic [6:0]  pci_idsel;
    logic        pci_ack = 1'b0;
    logic        pci_abort = 1'b0;
    logic [31:0] pci_rdata = 32'hA1B2_C3D4;
    logic        pci_rst_oe, pci_rst_out;

    always #4 clk = ~clk;

    pcx_bridge uut (
        .clk(clk), .rst_n(rst_n),
        .lb_valid(lb_valid), .lb_write(lb_write), .lb_addr(lb_addr),
        .lb_wdata(lb_wdata), .lb_size(lb_size), .lb_ready(lb_ready),
        .lb_rdata(lb_rdata), .lb_err(lb_err),
        .pci_req(pci_req), .pci_cfg(pci_cfg), .pci_write(pci_write),
        .pci_addr(pci_addr), .pci_wdata(pci_wdata), .pci_idsel(pci_idsel),
        .pci_ack(pci_ack), .pci_abort(pci_abort), .pci_rdata(pci_rdata),
        .pci_rst_oe(pci_rst_oe), .pci_rst_out(pci_rst_out)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [31:0] got_rdata, ph1_addr, last_wd;
    logic        got_err, ph1_cfg, ph1_write;
    logic [6:0]  ph1_idsel;
    int          got_nreq;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One local access with a zero-or-more-cycle responder; ab selects which PCI phase aborts.
    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          input logic [1:0] sz, input int ab, input int lat);
        logic [31:0] hold_addr;
        int          waited;
        bit          done;
        hold_addr = '0;
        waited    = 0;
        done      = 1'b0;
        got_nreq  = 0;
        @(negedge clk);
        lb_write = wr; lb_addr = a; lb_wdata = d; lb_size = sz; lb_valid = 1'b1;
        for (int cyc = 0; cyc < 64 && !done; cyc++) begin
            @(negedge clk);
            pci_ack = 1'b0;
            pci_abort = 1'b0;
            if (lb_ready) begin
                got_rdata = lb_rdata;
                got_err   = lb_err;
                lb_valid  = 1'b0;
                done      = 1'b1;
            end else if (pci_req) begin
                if (waited == 0) hold_addr = pci_addr;
                else check("R10 address held while waiting", pci_addr, hold_addr);
                if (got_nreq == 0 && waited == 0) begin
                    ph1_addr = pci_addr; ph1_cfg = pci_cfg;
                    ph1_idsel = pci_idsel; ph1_write = pci_write;
                end
                if (waited < lat) begin
                    waited++;
                end else begin
                    got_nreq++;
                    waited = 0;
                    if (pci_write) last_wd = pci_wdata;
                    if (ab == got_nreq) pci_abort = 1'b1;
                    else pci_ack = 1'b1;
                end
            end
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R10 access never completed actual=%0d expected=1", 0);
            lb_valid = 1'b0;
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  size;
        logic [1:0]  ab;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic [1:0]  exp_nreq;
        logic [31:0] exp_paddr;
        logic [31:0] exp_wd;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h8000_0000, 32'h0,         2'd2, 2'd0, 32'hA1B2_C3D4, 1'b0, 2'd1, 32'h0000_2000, 32'h0},
        '{1'b0, 32'h8000_190E, 32'h0,         2'd0, 2'd0, 32'h0000_00B2, 1'b0, 2'd1, 32'h0001_010C, 32'h0},
        '{1'b0, 32'h8000_373D, 32'h0,         2'd1, 2'd0, 32'h0000_B2C3, 1'b0, 2'd1, 32'h0008_073C, 32'h0},
        '{1'b0, 32'h8000_0002, 32'h0,         2'd2, 2'd0, 32'h0000_A1B2, 1'b0, 2'd1, 32'h0000_2000, 32'h0},
        '{1'b0, 32'h8000_0000, 32'h0,         2'd3, 2'd0, 32'hA1B2_C3D4, 1'b0, 2'd1, 32'h0000_2000, 32'h0},
        '{1'b0, 32'h8000_3800, 32'h0,         2'd2, 2'd0, 32'hFFFF_FFFF, 1'b1, 2'd0, 32'h0,         32'h0},
        '{1'b0, 32'h8000_9800, 32'h0,         2'd2, 2'd0, 32'hFFFF_FFFF, 1'b1, 2'd0, 32'h0,         32'h0},
        '{1'b1, 32'h8000_0805, 32'h0000_005A, 2'd0, 2'd0, 32'h0,         1'b0, 2'd2, 32'h0000_4004, 32'hA1B2_5AD4},
        '{1'b1, 32'h8000_1012, 32'h0000_BEEF, 2'd1, 2'd0, 32'h0,         1'b0, 2'd2, 32'h0000_8010, 32'hBEEF_C3D4},
        '{1'b1, 32'h8000_0010, 32'h1234_5678, 2'd2, 2'd0, 32'h0,         1'b0, 2'd2, 32'h0000_2010, 32'h1234_5678},
        '{1'b0, 32'h8000_0000, 32'h0,         2'd2, 2'd1, 32'hFFFF_FFFF, 1'b1, 2'd1, 32'h0000_2000, 32'h0},
        '{1'b1, 32'h8000_0804, 32'h0000_0001, 2'd2, 2'd1, 32'hFFFF_FFFF, 1'b1, 2'd1, 32'h0000_4004, 32'h0},
        '{1'b1, 32'h8000_0805, 32'h0000_005A, 2'd0, 2'd2, 32'hFFFF_FFFF, 1'b1, 2'd2, 32'h0000_4004, 32'hA1B2_5AD4}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: state held in reset
        check("R11 pci_req in reset", 32'(pci_req), 32'd0);
        check("R11 lb_ready in reset", 32'(lb_ready), 32'd0);
        check("R11 reset pin released", 32'(pci_rst_oe), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        access(1'b0, 32'h0000_0000, 32'h0, 2'd2, 0, 0);
        check("R11 control after reset", got_rdata, 32'h0);
        check("R1 register read makes no request", 32'(got_nreq), 32'd0);
        access(1'b0, 32'h0000_0004, 32'h0, 2'd2, 0, 0);
        check("R11 status after reset", got_rdata, 32'h0);

        access(1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 2'd2, 0, 0);
        access(1'b0, 32'h0000_0000, 32'h0, 2'd2, 0, 0);
        check("R3 control readback bits 5:1", got_rdata, 32'h0000_003E);

        access(1'b1, 32'h0000_0000, 32'h0000_0002, 2'd2, 0, 0);
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            access(v.wr, v.addr, v.wdata, v.size, int'(v.ab), 0);
            check($sformatf("R4/R7 err row %0d", i), 32'(got_err), 32'(v.exp_err));
            check($sformatf("R5/R7 rdata row %0d", i), got_rdata, v.exp_rd);
            check($sformatf("R6/R4 request count row %0d", i), 32'(got_nreq), 32'(v.exp_nreq));
            if (v.exp_nreq != 2'd0) begin
                check($sformatf("R3 config address row %0d", i), ph1_addr, v.exp_paddr);
                check($sformatf("R3 idsel row %0d", i), 32'(ph1_idsel), 32'(v.exp_paddr[19:13]));
                check($sformatf("R3 config flag row %0d", i), 32'(ph1_cfg), 32'd1);
                check($sformatf("R6 first phase reads row %0d", i), 32'(ph1_write), 32'd0);
            end
            if (v.exp_nreq == 2'd2)
                check($sformatf("R6 merged word row %0d", i), last_wd, v.exp_wd);
        end

        // R7 / R8: sticky abort flag, write-one-to-clear
        access(1'b0, 32'h0000_0004, 32'h0, 2'd2, 0, 0);
        check("R7 abort flag set", got_rdata, 32'h0400_0000);
        access(1'b1, 32'h0000_0004, 32'h0, 2'd2, 0, 0);
        access(1'b0, 32'h0000_0004, 32'h0, 2'd2, 0, 0);
        check("R8 zero write keeps flag", got_rdata, 32'h0400_0000);
        access(1'b1, 32'h0000_0004, 32'h0400_0000, 2'd2, 0, 0);
        access(1'b0, 32'h0000_0004, 32'h0, 2'd2, 0, 0);
        check("R8 one write clears flag", got_rdata, 32'h0);

        // R10: slow target
        access(1'b0, 32'h8000_0000, 32'h0, 2'd2, 0, 3);
        check("R10 slow config read data", got_rdata, 32'hA1B2_C3D4);
        check("R10 slow config read one request", 32'(got_nreq), 32'd1);

        // R2: memory mode, high bits 01
        access(1'b1, 32'h0000_0000, 32'h0000_0004, 2'd2, 0, 0);
        access(1'b0, 32'h8012_3456, 32'h0, 2'd2, 0, 2);
        check("R2 memory address", ph1_addr, 32'h4012_3456);
        check("R2 memory cycle type", 32'(ph1_cfg), 32'd0);
        check("R2 idsel idle in memory cycle", 32'(ph1_idsel), 32'd0);
        check("R2 memory read data", got_rdata, 32'hA1B2_C3D4);
        access(1'b1, 32'hBFFF_FFFC, 32'hCAFE_F00D, 2'd2, 0, 0);
        check("R2 memory write address", ph1_addr, 32'h7FFF_FFFC);
        check("R2 memory write single request", 32'(got_nreq), 32'd1);
        check("R2 memory write data", last_wd, 32'hCAFE_F00D);
        access(1'b0, 32'h8000_0040, 32'h0, 2'd2, 1, 0);
        check("R7 memory abort err", 32'(got_err), 32'd1);
        check("R7 memory abort data", got_rdata, 32'hFFFF_FFFF);
        access(1'b0, 32'hC000_0004, 32'h0, 2'd2, 0, 0);
        check("R1 upper address reaches status", got_rdata, 32'h0400_0000);
        check("R1 upper address makes no request", 32'(got_nreq), 32'd0);

        // R9: reset pin modes
        access(1'b1, 32'h0000_0000, 32'h0000_0010, 2'd2, 0, 0);
        check("R9 mode 1 enable", 32'(pci_rst_oe), 32'd1);
        check("R9 mode 1 level", 32'(pci_rst_out), 32'd0);
        access(1'b1, 32'h0000_0000, 32'h0000_0020, 2'd2, 0, 0);
        check("R9 mode 2 enable", 32'(pci_rst_oe), 32'd1);
        check("R9 mode 2 level", 32'(pci_rst_out), 32'd1);
        access(1'b1, 32'h0000_0000, 32'h0000_0030, 2'd2, 0, 0);
        check("R9 mode 3 released", 32'(pci_rst_oe), 32'd0);
        access(1'b1, 32'h0000_0000, 32'h0000_0000, 2'd2, 0, 0);
        check("R9 mode 0 released", 32'(pci_rst_oe), 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule